// File: doc/BRIEF.md
# Three-Channel Prescaled Down-Counter Timer

This block holds three independent 32-bit down-counters behind a small synchronous register bus. Each channel has a reload register, a live count register and a control register. The control register selects one of five clock divisions, holds a sticky underflow flag and holds an interrupt enable. One shared start register runs or pauses the channels one by one.

Each channel has its own free-running prescaler. The prescaler gives a one-cycle tick at the chosen division, and the count steps down by one on each tick. When the count steps from zero, it takes the reload value on that same tick and sets the underflow flag. The channel's interrupt output is high while both the flag and its enable are set. Software clears the flag by writing a zero to it.

Reads are combinational from the address. Writes take effect at the rising clock edge while the write enable is high.

Top module: `tmr3_unit`

## Requirements
- R1: Control bits [2:0] select the division. Codes 0, 1, 2, 3 and 4 make the count step down once every 4, 16, 64, 256 and 1024 running clock cycles. After a start from reset, the first step lands on the 4th, 16th, 64th, 256th or 1024th rising edge after the start write.
- R2: Control codes 5, 6 and 7 are invalid, and a channel set to one of them never changes its count.
- R3: Control bit 8 is the underflow flag and bit 5 is the interrupt enable. Output irq_o[n] is 1 exactly when both bits of channel n are 1.
- R4: A tick that finds the count at 0 loads the count with the reload register's value and sets the underflow flag.
- R5: Start register bits [2:0] run channels 0, 1 and 2. A channel whose bit is 0 holds its count, and its prescaler phase is held as well. Setting the bit again resumes counting from the held count. A channel never counts because another channel was started.
- R6: Writes to control register bits outside mask 0x013F for channels 0 and 1, and outside mask 0x03FF for channel 2, are dropped, and those bits read 0.
- R7: After reset, every reload and count register reads 0xFFFFFFFF. The control registers, the start register and the output-control register read 0, and all interrupt outputs are 0.
- R8: A count write sets the count at that clock edge and leaves the prescaler phase unchanged, so the next tick comes as it would have without the write. The write wins over a tick in the same cycle.
- R9: Writing 0 to control bit 8 clears the flag. Writing 1 to bit 8 leaves it unchanged. An underflow in the same cycle as a clearing write leaves the flag set.
- R10: Address map, in bytes: output control (8 bits, read/write) at 0x00, start register at 0x04, and for channel n the reload, count and control registers at 0x08+12n, 0x0C+12n and 0x10+12n. Address 0x2C always reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 6 | Byte address of the register |
| we_i | input | 1 | Write enable |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i |
| irq_o | output | 3 | Per-channel underflow interrupt |

## Verification
A table of runs spreads over all three channels and every division code. Each run is long enough for several ticks, so a wrong division ratio or a wrong first-tick phase shows up as a wrong count. Some runs start at a count of 0 or 1, which forces one or more reloads. These show whether the reload value and the flag are applied on the underflowing tick, and a run with the enable cleared separates the flag from the interrupt. The invalid codes 5, 6 and 7 run for hundreds of cycles to show that nothing moves. Directed cases then cover the stop and restart phase, a count write placed one edge before a tick, a flag clear that lands on the same edge as an underflow, and the writable-bit masks.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int NUM_CH    = 3;
  localparam int CNT_W     = 32;
  localparam int CTL_W     = 16;
  localparam int PSC_W     = 10;
  localparam int ADDR_W    = 6;
  localparam int OCR_W     = 8;
  localparam int A_OCR     = 'h00;
  localparam int A_STR     = 'h04;
  localparam int A_CH0     = 'h08;
  localparam int CH_STRIDE = 'h0C;
  localparam int FLAG_BIT  = 8;
  localparam int IE_BIT    = 5;
  localparam int MODE_MAX  = 4;

  function automatic logic [CTL_W-1:0] ctl_mask(input int ch);
    return (ch == NUM_CH - 1) ? 16'h03FF : 16'h013F;
  endfunction
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int PSC_W = tmr_pkg::PSC_W
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       run_i,
  input  logic [2:0] mode_i,
  output logic       tick_o
);
  logic [PSC_W-1:0] div_q;
  logic [PSC_W-1:0] sel_mask;
  logic             valid;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    div_q <= '0;
    else if (run_i) div_q <= div_q + 1'b1;
  end

  always_comb begin
    valid    = (int'(mode_i) <= tmr_pkg::MODE_MAX);
    sel_mask = '0;
    if (valid) sel_mask = PSC_W'((32'd4 << {mode_i, 1'b0}) - 32'd1);
  end

  assign tick_o = run_i & valid & ((div_q & sel_mask) == sel_mask);
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel #(
  parameter int              CNT_W    = tmr_pkg::CNT_W,
  parameter int              CTL_W    = tmr_pkg::CTL_W,
  parameter int              PSC_W    = tmr_pkg::PSC_W,
  parameter logic [CTL_W-1:0] CTL_MASK = 16'h013F
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             cor_we_i,
  input  logic             cnt_we_i,
  input  logic             ctl_we_i,
  input  logic [CNT_W-1:0] wdata_i,
  output logic [CNT_W-1:0] cor_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CTL_W-1:0] ctl_o,
  output logic             irq_o
);
  import tmr_pkg::FLAG_BIT;
  import tmr_pkg::IE_BIT;

  logic [CNT_W-1:0] cor_q, cnt_q;
  logic [CTL_W-1:0] ctl_q, ctl_d;
  logic             tick, uf;

  tmr_prescaler #(.PSC_W(PSC_W)) u_psc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (run_i),
    .mode_i (ctl_q[2:0]),
    .tick_o (tick)
  );

  assign uf = tick & ~cnt_we_i & (cnt_q == '0);

  always_comb begin
    ctl_d = ctl_q;
    if (ctl_we_i) ctl_d = (ctl_q & ~CTL_MASK) | (wdata_i[CTL_W-1:0] & CTL_MASK);
    // hw set beats sw clear; writing 1 keeps current value
    ctl_d[FLAG_BIT] = uf | (ctl_q[FLAG_BIT] & (~ctl_we_i | wdata_i[FLAG_BIT]));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cor_q <= '1;
      cnt_q <= '1;
      ctl_q <= '0;
    end else begin
      if (cor_we_i) cor_q <= wdata_i;
      if (cnt_we_i)  cnt_q <= wdata_i;
      else if (uf)   cnt_q <= cor_q;
      else if (tick) cnt_q <= cnt_q - 1'b1;
      ctl_q <= ctl_d;
    end
  end

  assign cor_o = cor_q;
  assign cnt_o = cnt_q;
  assign ctl_o = ctl_q;
  assign irq_o = ctl_q[FLAG_BIT] & ctl_q[IE_BIT];
endmodule

// File: rtl/tmr3_unit.sv
module tmr3_unit #(
  parameter int NUM_CH = tmr_pkg::NUM_CH,
  parameter int CNT_W  = tmr_pkg::CNT_W,
  parameter int CTL_W  = tmr_pkg::CTL_W,
  parameter int PSC_W  = tmr_pkg::PSC_W,
  parameter int ADDR_W = tmr_pkg::ADDR_W,
  parameter int OCR_W  = tmr_pkg::OCR_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [CNT_W-1:0]  wdata_i,
  output logic [CNT_W-1:0]  rdata_o,
  output logic [NUM_CH-1:0] irq_o
);
  import tmr_pkg::*;

  logic [OCR_W-1:0]             ocr_q;
  logic [NUM_CH-1:0]            str_q;
  logic [NUM_CH-1:0][CNT_W-1:0] cor_w, cnt_w;
  logic [NUM_CH-1:0][CTL_W-1:0] ctl_w;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ocr_q <= '0;
      str_q <= '0;
    end else if (we_i) begin
      if (addr_i == ADDR_W'(A_OCR)) ocr_q <= wdata_i[OCR_W-1:0];
      if (addr_i == ADDR_W'(A_STR)) str_q <= wdata_i[NUM_CH-1:0];
    end
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    localparam int BASE = A_CH0 + CH_STRIDE * c;
    tmr_channel #(
      .CNT_W    (CNT_W),
      .CTL_W    (CTL_W),
      .PSC_W    (PSC_W),
      .CTL_MASK (ctl_mask(c))
    ) u_ch (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .run_i    (str_q[c]),
      .cor_we_i (we_i && addr_i == ADDR_W'(BASE)),
      .cnt_we_i (we_i && addr_i == ADDR_W'(BASE + 4)),
      .ctl_we_i (we_i && addr_i == ADDR_W'(BASE + 8)),
      .wdata_i  (wdata_i),
      .cor_o    (cor_w[c]),
      .cnt_o    (cnt_w[c]),
      .ctl_o    (ctl_w[c]),
      .irq_o    (irq_o[c])
    );
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == ADDR_W'(A_OCR)) rdata_o = CNT_W'(ocr_q);
    if (addr_i == ADDR_W'(A_STR)) rdata_o = CNT_W'(str_q);
    for (int c = 0; c < NUM_CH; c++) begin
      if (addr_i == ADDR_W'(A_CH0 + CH_STRIDE * c))     rdata_o = cor_w[c];
      if (addr_i == ADDR_W'(A_CH0 + CH_STRIDE * c + 4)) rdata_o = cnt_w[c];
      if (addr_i == ADDR_W'(A_CH0 + CH_STRIDE * c + 8)) rdata_o = CNT_W'(ctl_w[c]);
    end
  end
endmodule

// File: rtl/tmr3_unit_chk.sv
module tmr3_unit_chk #(
  parameter int NUM_CH = tmr_pkg::NUM_CH,
  parameter int CNT_W  = tmr_pkg::CNT_W,
  parameter int CTL_W  = tmr_pkg::CTL_W,
  parameter int ADDR_W = tmr_pkg::ADDR_W
) (
  input logic                         clk_i,
  input logic                         rst_ni,
  input logic [ADDR_W-1:0]            addr_i,
  input logic                         we_i,
  input logic [NUM_CH-1:0]            str_i,
  input logic [NUM_CH-1:0][CNT_W-1:0] cor_i,
  input logic [NUM_CH-1:0][CNT_W-1:0] cnt_i,
  input logic [NUM_CH-1:0][CTL_W-1:0] ctl_i
);
  import tmr_pkg::*;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
    localparam int BASE = A_CH0 + CH_STRIDE * c;
    localparam logic [CTL_W-1:0] MASK = ctl_mask(c);
    logic cnt_wr, ctl_wr;
    assign cnt_wr = we_i && addr_i == ADDR_W'(BASE + 4);
    assign ctl_wr = we_i && addr_i == ADDR_W'(BASE + 8);

    a_r5_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!str_i[c] && !cnt_wr) |=> $stable(cnt_i[c]));

    a_r2_no_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ctl_i[c][2:0] > 3'd4 && !cnt_wr) |=> $stable(cnt_i[c]));

    a_r4_reload: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cnt_i[c] == '0 && !cnt_wr) |=>
        (cnt_i[c] == '0 || (cnt_i[c] == $past(cor_i[c]) && ctl_i[c][FLAG_BIT])));

    a_r9_flag_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ctl_i[c][FLAG_BIT] && !ctl_wr) |=> ctl_i[c][FLAG_BIT]);

    a_r6_mask_bits: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ctl_i[c] & ~MASK) == '0);
  end
endmodule

bind tmr3_unit tmr3_unit_chk u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .addr_i (addr_i),
  .we_i   (we_i),
  .str_i  (str_q),
  .cor_i  (cor_w),
  .cnt_i  (cnt_w),
  .ctl_i  (ctl_w)
);

// File: tb/tb_tmr3_unit.sv
module tb_tmr3_unit;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [5:0]  addr_i = '0;
  logic        we_i = 1'b0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic [2:0]  irq_o;

  int errs = 0;
  int checks = 0;
  bit done = 0;

  tmr3_unit dut (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .addr_i  (addr_i),
    .we_i    (we_i),
    .wdata_i (wdata_i),
    .rdata_o (rdata_o),
    .irq_o   (irq_o)
  );

  always #4 clk_i = ~clk_i;

  localparam int NV = 8;
  localparam int          V_CH   [NV] = '{0, 0, 1, 2, 0, 1, 2, 0};
  localparam int          V_MODE [NV] = '{0, 0, 1, 2, 5, 7, 6, 4};
  localparam logic [31:0] V_INIT [NV] = '{10, 2, 3, 1, 50, 50, 50, 5};
  localparam logic [31:0] V_REL  [NV] = '{5, 7, 100, 0, 1, 1, 1, 9};
  localparam int          V_IE   [NV] = '{1, 1, 0, 1, 1, 1, 1, 0};
  localparam int          V_CYC  [NV] = '{20, 20, 160, 640, 400, 400, 400, 5000};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    addr_i = 6'(a); wdata_i = d; we_i = 1'b1;
    @(posedge clk_i); #1;
    we_i = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    addr_i = 6'(a); #1;
    d = rdata_o;
  endtask

  task automatic do_reset();
    we_i = 1'b0; rst_ni = 1'b0;
    repeat (2) @(posedge clk_i);
    #1 rst_ni = 1'b1;
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk_i);
    #1;
  endtask

  function automatic void model(input int mode, input logic [31:0] init, input logic [31:0] rel,
                                input int cyc, output logic [31:0] c, output logic f);
    int ticks;
    ticks = (mode < 5) ? cyc / (4 << (2 * mode)) : 0;
    c = init; f = 1'b0;
    for (int t = 0; t < ticks; t++) begin
      if (c == 0) begin c = rel; f = 1'b1; end
      else c = c - 1;
    end
  endfunction

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      errs++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errs, checks + 1);
      $finish;
    end
  end

  initial begin
    logic [31:0] d, ec;
    logic ef;
    do_reset();

    // R7 reset state, R10 map
    for (int c = 0; c < 3; c++) begin
      rd(8 + 12 * c, d);  chk("R7 reload reset", d, 32'hFFFF_FFFF);
      rd(12 + 12 * c, d); chk("R7 count reset", d, 32'hFFFF_FFFF);
      rd(16 + 12 * c, d); chk("R7 control reset", d, 0);
    end
    rd(4, d); chk("R7 start reset", d, 0);
    rd(0, d); chk("R7 output control reset", d, 0);
    chk("R7 irq reset", 32'(irq_o), 0);

    // R10 output control storage, capture placeholder
    wr(0, 32'hFFFF_FFA5); rd(0, d); chk("R10 output control rw", d, 32'hA5);
    wr('h2C, 32'h1234_5678); rd('h2C, d); chk("R10 capture reads 0", d, 0);

    // R6 writable masks
    wr('h10, 32'hFFFF); rd('h10, d); chk("R6 ch0 mask", d, 32'h003F);
    wr('h1C, 32'hFFFF); rd('h1C, d); chk("R6 ch1 mask", d, 32'h003F);
    wr('h28, 32'hFFFF); rd('h28, d); chk("R6 ch2 mask", d, 32'h02FF);

    // R1 R2 R3 R4: vector table
    for (int v = 0; v < NV; v++) begin
      int base, oth;
      string tag;
      do_reset();
      base = 8 + 12 * V_CH[v];
      oth  = (V_CH[v] + 1) % 3;
      tag  = (V_MODE[v] < 5) ? "R1 R4 count" : "R2 invalid code count";
      wr(base, V_REL[v]);
      wr(base + 4, V_INIT[v]);
      wr(base + 8, 32'(V_MODE[v] | (V_IE[v] << 5)));
      wr(4, 32'(1 << V_CH[v]));
      step(V_CYC[v]);
      model(V_MODE[v], V_INIT[v], V_REL[v], V_CYC[v], ec, ef);
      rd(base + 4, d); chk(tag, d, ec);
      rd(base + 8, d); chk("R4 flag", 32'(d[8]), 32'(ef));
      chk("R3 irq gate", 32'(irq_o[V_CH[v]]), 32'(ef & (V_IE[v] != 0)));
      rd(12 + 12 * oth, d); chk("R5 idle channel holds", d, 32'hFFFF_FFFF);
    end

    // R5 stop holds, restart resumes
    do_reset();
    wr('h0C, 100); wr('h10, 0); wr(4, 1);
    step(8); rd('h0C, d); chk("R5 running", d, 98);
    wr(4, 0); step(20); rd('h0C, d); chk("R5 stopped holds", d, 98);
    wr(4, 1); step(4); rd('h0C, d); chk("R5 resume", d, 97);

    // R8 count write keeps prescaler phase
    do_reset();
    wr('h0C, 100); wr('h10, 0); wr(4, 1);
    step(2); wr('h0C, 50);
    rd('h0C, d); chk("R8 immediate load", d, 50);
    step(1); rd('h0C, d); chk("R8 phase kept", d, 49);

    // R9 flag clear rules, R3 irq follows
    do_reset();
    wr(8, 3); wr('h0C, 0); wr('h10, 32'h20); wr(4, 1);
    step(4);
    rd('h0C, d); chk("R4 reload on underflow", d, 3);
    chk("R3 irq raised", 32'(irq_o[0]), 1);
    wr(4, 0);
    wr('h10, 32'h120); rd('h10, d); chk("R9 write 1 keeps flag", d, 32'h120);
    wr('h10, 32'h020); rd('h10, d); chk("R9 write 0 clears flag", d, 32'h020);
    chk("R3 irq cleared", 32'(irq_o[0]), 0);

    // R9 underflow beats simultaneous clear
    do_reset();
    wr('h0C, 0); wr('h10, 0); wr(4, 1);
    step(3); wr('h10, 0);
    rd('h10, d); chk("R9 set beats clear", 32'(d[8]), 1);
    rd('h0C, d); chk("R4 reload default", d, 32'hFFFF_FFFF);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule